// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a persistent record of why the most recent system reset took place. It lives in a retention domain. Only its own retention reset `ret_rst_n` clears it. The system resets it reports on do not touch it. Each reset generator sends a one-cycle pulse on its own lane of `cause_pulse`. The matching flag then sets, and every other flag keeps the value it had before.

Software reads the register over a simple 16-bit port. It can access the register as a word or as either byte, using two byte enables. After it has worked out the cause, it writes ones to the flags it has handled. The usual way is a single word write of 0xFFFF, which leaves the register ready for the next reset.

A separate start-up abnormality flag is read-only. A small phase machine follows the system reset line and loads this flag from the `startup_err` input once each reset is released. The phase machine has three states:
- RUN: normal operation. It moves to HELD while `sys_rst_active` is high.
- HELD: the system reset is asserted. It moves to LATCH once `sys_rst_active` drops.
- LATCH: a one-cycle window in which bit 7 is loaded. It goes back to RUN, or to HELD if the reset is asserted again.

Top module: `rcs_top`

## Requirements
- R1: A pulse on lane i of `cause_pulse` sets that cause's flag at the next rising edge. Flags of lanes without a pulse keep their value, except as R7 states.
- R2: The lanes map to register bits as follows. Lane 0 (power-on) is bit 0. Lane 1 (watchdog overflow) is bit 2. Lane 2 (watchdog invalid clear) is bit 3. Lane 3 (voltage supervisor) is bit 4. Lane 4 (reset pin) is bit 6. Lane 5 (break-instruction CPU reset) is bit 8. The start-up abnormality flag is bit 7.
- R3: Bits 1, 5 and 9 to 15 always read 0, and writes have no effect on them.
- R4: A write clears each cause flag whose bit in `wdata` is 1 and whose byte is enabled. `be[0]` enables bits 7:0 and `be[1]` enables bits 15:8. A 0 bit, or a disabled byte, leaves the flag unchanged.
- R5: A word write of 0xFFFF with `be`=2'b11 clears all six cause flags at once.
- R6: Bit 7 ignores writes. It is loaded from `startup_err` only at the rising edge that ends the LATCH phase, which is the second rising edge at which `sys_rst_active` is sampled low after being high.
- R7: A power-on pulse (lane 0) clears every other cause flag whose lane is not pulsing in the same cycle.
- R8: When a cause pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: `rdata` always shows the current register contents, including a set made at the previous edge. Reads and `sys_rst_active` never change any flag.
- R10: An asserted `ret_rst_n` clears all flags, including bit 7, and puts the phase machine in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Retention-domain clock |
| ret_rst_n | input | 1 | Asynchronous active-low retention-domain reset |
| sys_rst_active | input | 1 | High while a system reset is being applied |
| startup_err | input | 1 | Start-up abnormality indication, loaded into bit 7 after each reset release |
| cause_pulse | input | 6 | One-cycle reset cause pulses, one lane per cause as listed in R2 |
| wr_en | input | 1 | Write strobe |
| be | input | 2 | Byte enables: bit 0 for the low byte, bit 1 for the high byte |
| wdata | input | 16 | Write data, a 1 clears the corresponding flag |
| rdata | output | 16 | Register contents |

## Verification
The assertions check these behaviours on every cycle:
- each pulse sets its flag;
- a flag with no pulse, no enabled clearing one and no power-on pulse holds its value;
- an enabled clearing write or a power-on pulse leaves a flag clear when its own lane is quiet;
- reserved bits stay zero;
- bit 7 changes only after the LATCH phase.

Other behaviours only the bench's scenarios can show:
- that the lane-to-bit map matches the requirement;
- that bit 7 captures the right `startup_err` value through a full reset sequence;
- that a value changed while running is ignored;
- that long random mixes of pulses, byte writes and word clears leave exactly the expected contents.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    localparam int DATA_W      = 16;
    localparam int NBYTE       = DATA_W / 8;
    localparam int NCAUSE      = 6;
    localparam int LANE_POR    = 0;
    localparam int STARTUP_POS = 7;
    // register bit of each cause lane: por, wdt overflow, wdt invalid clear,
    // voltage supervisor, reset pin, break instruction
    localparam int CAUSE_POS [NCAUSE] = '{0, 2, 3, 4, 6, 8};

    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_HELD  = 2'd1,
        PH_LATCH = 2'd2
    } phase_e;
endpackage

// File: rtl/rcs_phase_fsm.sv
module rcs_phase_fsm
    import rcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sys_rst_active,
    output phase_e phase_o,
    output logic   latch_o
);
    phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_RUN:   if (sys_rst_active)  state_d = PH_HELD;
            PH_HELD:  if (!sys_rst_active) state_d = PH_LATCH;
            PH_LATCH: state_d = sys_rst_active ? PH_HELD : PH_RUN;
            default:  state_d = PH_RUN;
        endcase
    end

    always_comb begin
        phase_o = state_q;
        latch_o = (state_q == PH_LATCH);
    end
endmodule

// File: rtl/rcs_flag_bank.sv
module rcs_flag_bank
    import rcs_pkg::*;
#(
    parameter int N_FLAG = NCAUSE,
    parameter int POR_LANE = LANE_POR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FLAG-1:0] set_i,
    input  logic [N_FLAG-1:0] clr_i,
    output logic [N_FLAG-1:0] flag_o
);
    logic por_hit;
    assign por_hit = set_i[POR_LANE];

    for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   q <= 1'b0;
            else if (set_i[i])            q <= 1'b1;
            else if (clr_i[i] || por_hit) q <= 1'b0;
        end
        assign flag_o[i] = q;
    end
endmodule

// File: rtl/rcs_bus_map.sv
module rcs_bus_map
    import rcs_pkg::*;
(
    input  logic              wr_en,
    input  logic [NBYTE-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NCAUSE-1:0] flags,
    input  logic              startup_q,
    output logic [NCAUSE-1:0] clr_o,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cause_bits;

    for (genvar i = 0; i < NCAUSE; i++) begin : g_lane
        localparam int POS = CAUSE_POS[i];
        assign clr_o[i] = wr_en && be[POS/8] && wdata[POS];
    end

    always_comb begin
        cause_bits = '0;
        for (int i = 0; i < NCAUSE; i++) cause_bits[CAUSE_POS[i]] = flags[i];
        rdata = cause_bits;
        rdata[STARTUP_POS] = startup_q;
    end
endmodule

// File: rtl/rcs_top.sv
module rcs_top
    import rcs_pkg::*;
(
    input  logic              clk,
    input  logic              ret_rst_n,
    input  logic              sys_rst_active,
    input  logic              startup_err,
    input  logic [NCAUSE-1:0] cause_pulse,
    input  logic              wr_en,
    input  logic [NBYTE-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    phase_e            phase;
    logic              latch;
    logic              startup_q;
    logic [NCAUSE-1:0] clr;
    logic [NCAUSE-1:0] flags;

    rcs_phase_fsm u_fsm (
        .clk            (clk),
        .rst_n          (ret_rst_n),
        .sys_rst_active (sys_rst_active),
        .phase_o        (phase),
        .latch_o        (latch)
    );

    always_ff @(posedge clk or negedge ret_rst_n) begin
        if (!ret_rst_n) startup_q <= 1'b0;
        else if (latch) startup_q <= startup_err;
    end

    rcs_flag_bank #(.N_FLAG(NCAUSE), .POR_LANE(LANE_POR)) u_bank (
        .clk    (clk),
        .rst_n  (ret_rst_n),
        .set_i  (cause_pulse),
        .clr_i  (clr),
        .flag_o (flags)
    );

    rcs_bus_map u_map (
        .wr_en     (wr_en),
        .be        (be),
        .wdata     (wdata),
        .flags     (flags),
        .startup_q (startup_q),
        .clr_o     (clr),
        .rdata     (rdata)
    );
endmodule

// File: rtl/rcs_top_chk.sv
module rcs_top_chk
    import rcs_pkg::*;
(
    input logic              clk,
    input logic              ret_rst_n,
    input logic [NCAUSE-1:0] cause_pulse,
    input logic              wr_en,
    input logic [NBYTE-1:0]  be,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input phase_e            phase
);
    localparam logic [DATA_W-1:0] RSV_MASK = 16'hFE22;

    // R3: reserved bits never read as one
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!ret_rst_n)
        (rdata & RSV_MASK) == '0);

    // R6: bit 7 only moves right after the LATCH phase
    a_r6_startup_only_latch: assert property (@(posedge clk) disable iff (!ret_rst_n)
        !$stable(rdata[STARTUP_POS]) |-> $past(phase == PH_LATCH));

    for (genvar i = 0; i < NCAUSE; i++) begin : g_chk
        localparam int POS = CAUSE_POS[i];

        // R1 and R8: a pulse always sets its flag
        a_r1_pulse_sets: assert property (@(posedge clk) disable iff (!ret_rst_n)
            cause_pulse[i] |=> rdata[POS]);

        // R4: an enabled clearing write with a quiet lane clears
        a_r4_write_one_clears: assert property (@(posedge clk) disable iff (!ret_rst_n)
            (wr_en && be[POS/8] && wdata[POS] && !cause_pulse[i]) |=> !rdata[POS]);

        // R7: power-on pulse wipes other quiet lanes
        a_r7_por_wipes: assert property (@(posedge clk) disable iff (!ret_rst_n)
            (cause_pulse[LANE_POR] && !cause_pulse[i]) |=> !rdata[POS]);

        // R9: no pulse, no clear, no power-on means the flag holds
        a_r9_flag_holds: assert property (@(posedge clk) disable iff (!ret_rst_n)
            (!cause_pulse[i] && !cause_pulse[LANE_POR] &&
             !(wr_en && be[POS/8] && wdata[POS])) |=> $stable(rdata[POS]));
    end
endmodule

bind rcs_top rcs_top_chk u_chk (
    .clk         (clk),
    .ret_rst_n   (ret_rst_n),
    .cause_pulse (cause_pulse),
    .wr_en       (wr_en),
    .be          (be),
    .wdata       (wdata),
    .rdata       (rdata),
    .phase       (phase)
);

// File: tb/rcs_top_test.sv
module rcs_top_test;
    import rcs_pkg::*;

    logic              clk = 1'b0;
    logic              ret_rst_n = 1'b0;
    logic              sys_rst_active = 1'b0;
    logic              startup_err = 1'b0;
    logic [NCAUSE-1:0] cause_pulse = '0;
    logic              wr_en = 1'b0;
    logic [NBYTE-1:0]  be = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;

    int checks = 0;
    int failures = 0;
    logic [DATA_W-1:0] exp_q = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rcs_top uut (
        .clk(clk), .ret_rst_n(ret_rst_n), .sys_rst_active(sys_rst_active),
        .startup_err(startup_err), .cause_pulse(cause_pulse), .wr_en(wr_en),
        .be(be), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [DATA_W-1:0] model(input logic [DATA_W-1:0] cur,
        input logic [NCAUSE-1:0] p, input logic w, input logic [NBYTE-1:0] b,
        input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r = cur;
        for (int i = 0; i < NCAUSE; i++) begin
            int pos = CAUSE_POS[i];
            if (p[i]) r[pos] = 1'b1;
            else if ((w && b[pos/8] && d[pos]) || p[LANE_POR]) r[pos] = 1'b0;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [DATA_W-1:0] exp);
        checks++;
        if (rdata !== exp) begin
            failures++;
            $display("FAIL %s rdata=%h expected=%h", req, rdata, exp);
        end
    endtask

    task automatic step(input string req, input logic [NCAUSE-1:0] p, input logic w,
        input logic [NBYTE-1:0] b, input logic [DATA_W-1:0] d, input logic sr);
        cause_pulse = p; wr_en = w; be = b; wdata = d; sys_rst_active = sr;
        exp_q = model(exp_q, p, w, b, d);
        @(negedge clk);
        check(req, exp_q);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk); @(negedge clk);
        check("R10 in reset", 16'h0000);
        ret_rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset", 16'h0000);

        // R2: each lane lands on its own bit
        step("R2 lane4 pin -> bit6", 6'b010000, 0, 2'b00, 0, 0);
        if (rdata !== 16'h0040) begin failures++; $display("FAIL R2 rdata=%h expected=0040", rdata); end
        checks++;
        step("R2 lane5 brk -> bit8", 6'b100000, 0, 2'b00, 0, 0);
        step("R1 lane2 wdt invalid -> bit3", 6'b000100, 0, 2'b00, 0, 0);
        if (rdata !== 16'h0148) begin failures++; $display("FAIL R2 rdata=%h expected=0148", rdata); end
        checks++;
        // R4: bit8 write with only low byte enabled has no effect
        step("R4 disabled byte", 6'b0, 1, 2'b01, 16'h0100, 0);
        // R4: write zero has no effect
        step("R4 write zero", 6'b0, 1, 2'b11, 16'h0000, 0);
        // R4: high-byte write clears bit8
        step("R4 high byte clears", 6'b0, 1, 2'b10, 16'hFFFF, 0);
        // R8: set wins over clear on bit6
        step("R8 set wins", 6'b010000, 1, 2'b01, 16'h0040, 0);
        // R3: reserved bits ignore writes
        step("R3 reserved", 6'b0, 1, 2'b11, 16'h0000, 0);
        // R5: word 0xFFFF clears all
        step("R5 word clear", 6'b0, 1, 2'b11, 16'hFFFF, 0);
        if (rdata !== 16'h0000) begin failures++; $display("FAIL R5 rdata=%h expected=0000", rdata); end
        checks++;
        // R7: power-on wipes others, simultaneous lane survives
        step("R7 setup", 6'b011110, 0, 2'b00, 0, 0);
        step("R7 por with lane1", 6'b000011, 0, 2'b00, 0, 0);
        if (rdata !== 16'h0005) begin failures++; $display("FAIL R7 rdata=%h expected=0005", rdata); end
        checks++;

        // R6 / R9: reset sequence loads bit7, flags survive
        startup_err = 1'b1;
        step("R9 sys reset held", 6'b010000, 0, 2'b00, 0, 1);
        step("R9 sys reset held", 6'b0, 0, 2'b00, 0, 1);
        step("R6 first low edge", 6'b0, 0, 2'b00, 0, 0);
        exp_q[STARTUP_POS] = 1'b1;
        step("R6 bit7 captured", 6'b0, 0, 2'b00, 0, 0);
        startup_err = 1'b0;
        step("R6 bit7 ignores later input", 6'b0, 0, 2'b00, 0, 0);
        step("R6 bit7 ignores writes", 6'b0, 1, 2'b11, 16'hFFFF, 0);
        step("R6 second reset", 6'b0, 0, 2'b00, 0, 1);
        step("R6 second low edge", 6'b0, 0, 2'b00, 0, 0);
        exp_q[STARTUP_POS] = 1'b0;
        step("R6 bit7 recaptured 0", 6'b0, 0, 2'b00, 0, 0);

        // random mix: R1 R3 R4 R5 R7 R8 R9
        for (int n = 0; n < 3000; n++) begin
            logic [NCAUSE-1:0] p;
            logic w;
            logic [DATA_W-1:0] d;
            for (int i = 0; i < NCAUSE; i++) p[i] = ($urandom % 8) == 0;
            if (($urandom % 4) != 0) p[LANE_POR] = 1'b0;
            w = ($urandom % 3) == 0;
            d = (($urandom % 5) == 0) ? 16'hFFFF : 16'($urandom);
            step("R1 random mix", p, w, 2'($urandom), d, 0);
        end
        step("R9 idle", 6'b0, 0, 2'b00, 0, 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule